// File: doc/BRIEF.md
# Clipped-Delay Event Metric Accumulator

This block measures how well a workload meets its latency goals, event by event. Each event is opened by a one-cycle start pulse and closed by a one-cycle done pulse. The block times every event in ticks of a prescaled time base. An event that finishes early is not credited for its early finish: it is charged its deadline instead, so each event adds the larger of its delay and its deadline to a running total. The total and the number of charged events are the figures software or a test harness reads to compare scheduling policies.

There are two deadline modes. In fixed mode every event has the same deadline, taken from an input word, which suits interactive work with a perception bound. In next-arrival mode an event's deadline is the time from its own start to the start of the following event, which suits periodic data streams. The block also watches buffering: at most two events may be open at once (one being processed, one buffered). A start that would open a third event is dropped and raises a sticky insufficiency flag.

Top module: `clipdelay_acc`

## Requirements
- R1: After reset, and on the clock edge after `clr` is sampled high, `clip_sum`, `ev_count` and `insufficient` are zero and every open event is discarded, so a later `ev_done` charges nothing.
- R2: An event's delay is the number of time-base ticks on the clock edges after the edge that sampled its start, up to and including the edge that samples its done; with `mode_next` = 0 the event adds max(delay, `fixed_deadline`) to `clip_sum` and 1 to `ev_count` on its done edge.
- R3: Up to two events may be open at once and each is timed from its own start; `ev_done` always closes the oldest open event.
- R4: An `ev_start` sampled while two events are open and `ev_done` is low is dropped (never charged) and sets `insufficient`, which stays 1 until reset or `clr`; if `ev_done` is high on that same edge, the oldest event closes first and the start is accepted without setting the flag.
- R5: With `mode_next` = 1, an event's deadline is its tick count up to the next accepted start; if it finishes before that start, its charge (equal to that deadline) and its count increment appear on the edge of the next start; if it finishes after it, it is charged max(delay, deadline) on its done edge; `fixed_deadline` is not used.
- R6: An `ev_done` sampled while no event is open changes neither `clip_sum` nor `ev_count`.
- R7: `clip_sum` saturates at 2^SUM_W-1 and `ev_count` at 2^CNT_W-1 instead of wrapping.
- R8: The time base advances one tick every PRESCALE clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of all state |
| ev_start | input | 1 | One-cycle pulse opening an event |
| ev_done | input | 1 | One-cycle pulse closing the oldest open event |
| mode_next | input | 1 | 0: fixed deadline, 1: deadline at the next event's arrival |
| fixed_deadline | input | DLY_W | Deadline in ticks for fixed mode |
| clip_sum | output | SUM_W | Saturating sum of clipped delays in ticks |
| ev_count | output | CNT_W | Saturating count of charged events |
| insufficient | output | 1 | Sticky flag: a start arrived with two events open |

## Verification
A slot timer that is off by one or loaded at the wrong time shows up in `clip_sum` on the very edge the event closes, as a charge that differs from the delay or deadline worked out from pulse spacing. A wrong occupancy count becomes visible at the next start: either the flag rises with fewer than two events open, or a third event is accepted and later adds an extra count. A lost or stuck pending event in next-arrival mode appears at the following start, when `ev_count` fails to step or steps without the matching charge.

// File: rtl/clipdelay_pkg.sv
package clipdelay_pkg;

  typedef enum logic {
    DL_FIXED = 1'b0,
    DL_NEXT  = 1'b1
  } dl_mode_e;

  localparam int unsigned DEF_SLOTS = 2;

endpackage

// File: rtl/cda_tick_gen.sv
module cda_tick_gen #(
  parameter int unsigned PRESCALE = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned PW   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] div_q, div_d;

  assign tick = (div_q == LAST);

  always_comb begin
    div_d = div_q;
    if (clr || tick) div_d = '0;
    else             div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/cda_event_tracker.sv
module cda_event_tracker
  import clipdelay_pkg::*;
#(
  parameter int unsigned DLY_W = 16,
  parameter int unsigned SLOTS = DEF_SLOTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             start,
  input  logic             done,
  input  logic             next_mode,
  input  logic [DLY_W-1:0] fixed_dl,
  output logic             chg_vld,
  output logic [DLY_W-1:0] chg_val,
  output logic             rejected,
  output logic [$clog2(SLOTS+1)-1:0] occ
);
  localparam int unsigned IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int unsigned OW = $clog2(SLOTS + 1);
  localparam logic [DLY_W-1:0] DMAX = {DLY_W{1'b1}};

  function automatic logic [DLY_W-1:0] sat_inc(input logic [DLY_W-1:0] v);
    return (v == DMAX) ? v : v + 1'b1;
  endfunction

  function automatic logic [DLY_W-1:0] max_of(input logic [DLY_W-1:0] a,
                                                input logic [DLY_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [IW-1:0] wrap(input int unsigned v);
    return IW'(v % SLOTS);
  endfunction

  dl_mode_e          mode;
  logic [IW-1:0]     head_q, head_d, tail_idx, newest_idx;
  logic [OW-1:0]     occ_q, occ_d, occ_after;
  logic              pend_q, pend_d;
  logic [DLY_W-1:0]  pcnt_q, pcnt_d, pcnt_el;
  logic              do_done, do_start;
  logic [SLOTS-1:0]  load_v, freeze_v, frz_w;
  logic [DLY_W-1:0]  el   [SLOTS];
  logic [DLY_W-1:0]  dl_w [SLOTS];

  assign mode = dl_mode_e'(next_mode);
  assign occ  = occ_q;

  // Control next state: retire oldest, admit new, freeze deadlines
  always_comb begin
    do_done    = done && (occ_q != '0);
    occ_after  = occ_q - OW'(do_done);
    do_start   = start && (occ_after < OW'(SLOTS));
    rejected   = start && !do_start;
    tail_idx   = wrap(int'(head_q) + int'(occ_q));
    newest_idx = wrap(int'(head_q) + int'(occ_q) + SLOTS - 1);
    pcnt_el    = tick ? sat_inc(pcnt_q) : pcnt_q;

    chg_vld  = 1'b0;
    chg_val  = '0;
    pend_d   = pend_q;
    pcnt_d   = pcnt_el;
    load_v   = '0;
    freeze_v = '0;

    if (do_done) begin
      if (mode == DL_FIXED) begin
        chg_vld = 1'b1;
        chg_val = max_of(el[head_q], fixed_dl);
      end else if (frz_w[head_q]) begin
        chg_vld = 1'b1;
        chg_val = max_of(el[head_q], dl_w[head_q]);
      end else if (do_start) begin
        chg_vld = 1'b1;
        chg_val = el[head_q];
      end else begin
        pend_d = 1'b1;
        pcnt_d = el[head_q];
      end
    end

    if (do_start) begin
      load_v[tail_idx] = 1'b1;
      if (pend_q) begin
        chg_vld = 1'b1;
        chg_val = pcnt_el;
        pend_d  = 1'b0;
      end
      if ((occ_q != '0) && !(do_done && (newest_idx == head_q)))
        freeze_v[newest_idx] = 1'b1;
    end

    head_d = do_done ? wrap(int'(head_q) + 1) : head_q;
    occ_d  = occ_after + OW'(do_start);

    if (clr) begin
      chg_vld = 1'b0;
      head_d  = '0;
      occ_d   = '0;
      pend_d  = 1'b0;
      pcnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      occ_q  <= '0;
      pend_q <= 1'b0;
      pcnt_q <= '0;
    end else begin
      head_q <= head_d;
      occ_q  <= occ_d;
      pend_q <= pend_d;
      pcnt_q <= pcnt_d;
    end
  end

  // One timer slot per allowed in-flight event
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [DLY_W-1:0] cnt_q, cnt_d, dl_q, dl_d;
    logic             frz_q, frz_d, en;

    assign el[i]    = tick ? sat_inc(cnt_q) : cnt_q;
    assign dl_w[i]  = dl_q;
    assign frz_w[i] = frz_q;
    assign en       = clr | load_v[i] | freeze_v[i] | tick;

    always_comb begin
      cnt_d = cnt_q;
      dl_d  = dl_q;
      frz_d = frz_q;
      if (clr || load_v[i]) begin
        cnt_d = '0;
        dl_d  = '0;
        frz_d = 1'b0;
      end else begin
        cnt_d = el[i];
        if (freeze_v[i]) begin
          frz_d = 1'b1;
          dl_d  = el[i];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        dl_q  <= '0;
        frz_q <= 1'b0;
      end else if (en) begin
        cnt_q <= cnt_d;
        dl_q  <= dl_d;
        frz_q <= frz_d;
      end
    end
  end
endmodule

// File: rtl/cda_accum.sv
module cda_accum #(
  parameter int unsigned DLY_W = 16,
  parameter int unsigned SUM_W = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             chg_vld,
  input  logic [DLY_W-1:0] chg_val,
  output logic [SUM_W-1:0] sum,
  output logic [CNT_W-1:0] count
);
  localparam int unsigned XW = ((SUM_W > DLY_W) ? SUM_W : DLY_W) + 1;
  localparam logic [XW-1:0]    SUM_MAX_X = XW'({SUM_W{1'b1}});
  localparam logic [SUM_W-1:0] SUM_MAX   = {SUM_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};

  logic [SUM_W-1:0] sum_d;
  logic [CNT_W-1:0] cnt_d;
  logic [XW-1:0]    add_x;
  logic             en;

  assign add_x = XW'(sum) + XW'(chg_val);
  assign en    = clr | chg_vld;

  always_comb begin
    sum_d = sum;
    cnt_d = count;
    if (clr) begin
      sum_d = '0;
      cnt_d = '0;
    end else if (chg_vld) begin
      sum_d = (add_x > SUM_MAX_X) ? SUM_MAX : add_x[SUM_W-1:0];
      cnt_d = (count == CNT_MAX) ? count : count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum   <= '0;
      count <= '0;
    end else if (en) begin
      sum   <= sum_d;
      count <= cnt_d;
    end
  end
endmodule

// File: rtl/clipdelay_acc.sv
module clipdelay_acc
  import clipdelay_pkg::*;
#(
  parameter int unsigned PRESCALE     = 100,
  parameter int unsigned DLY_W        = 16,
  parameter int unsigned SUM_W        = 32,
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned MAX_INFLIGHT = DEF_SLOTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ev_start,
  input  logic             ev_done,
  input  logic             mode_next,
  input  logic [DLY_W-1:0] fixed_deadline,
  output logic [SUM_W-1:0] clip_sum,
  output logic [CNT_W-1:0] ev_count,
  output logic             insufficient
);
  localparam int unsigned OW = $clog2(MAX_INFLIGHT + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic             tick;
  logic             chg_vld, rejected;
  logic [DLY_W-1:0] chg_val;
  logic [OW-1:0]    occ;
  logic             flag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  cda_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (clr),
    .tick  (tick)
  );

  cda_event_tracker #(.DLY_W(DLY_W), .SLOTS(MAX_INFLIGHT)) u_track (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .clr       (clr),
    .tick      (tick),
    .start     (ev_start),
    .done      (ev_done),
    .next_mode (mode_next),
    .fixed_dl  (fixed_deadline),
    .chg_vld   (chg_vld),
    .chg_val   (chg_val),
    .rejected  (rejected),
    .occ       (occ)
  );

  cda_accum #(.DLY_W(DLY_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .clr     (clr),
    .chg_vld (chg_vld),
    .chg_val (chg_val),
    .sum     (clip_sum),
    .count   (ev_count)
  );

  always_comb begin
    flag_d = insufficient;
    if (clr)           flag_d = 1'b0;
    else if (rejected) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) insufficient <= 1'b0;
    else             insufficient <= flag_d;
  end
endmodule

// File: rtl/clipdelay_acc_chk.sv
module clipdelay_acc_chk #(
  parameter int unsigned SUM_W = 32,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned MAX_INFLIGHT = 2,
  parameter int unsigned OW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             ev_start,
  input logic             ev_done,
  input logic [SUM_W-1:0] clip_sum,
  input logic [CNT_W-1:0] ev_count,
  input logic             insufficient,
  input logic [OW-1:0]    occ
);
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (clip_sum == '0 && ev_count == '0 && !insufficient)); // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (ev_count == $past(ev_count)) ||
             (ev_count == $past(ev_count) + 1'b1)); // R2

  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(MAX_INFLIGHT)); // R3

  AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OW'(MAX_INFLIGHT) && ev_start && !ev_done && !clr) |=> insufficient); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (insufficient && !clr) |=> insufficient); // R4

  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0 && !ev_start && !clr) |=> $stable(ev_count)); // R6

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> clip_sum >= $past(clip_sum)); // R7
endmodule

bind clipdelay_acc clipdelay_acc_chk #(
  .SUM_W(SUM_W), .CNT_W(CNT_W), .MAX_INFLIGHT(MAX_INFLIGHT), .OW(OW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clr          (clr),
  .ev_start     (ev_start),
  .ev_done      (ev_done),
  .clip_sum     (clip_sum),
  .ev_count     (ev_count),
  .insufficient (insufficient),
  .occ          (occ)
);

// File: tb/clipdelay_acc_test.sv
`timescale 1ns/1ps
module clipdelay_acc_test;
  logic        clk = 1'b0;
  logic        rst_n, clr, ev_start, ev_done, mode_next;
  logic [15:0] fixed_deadline;
  logic [11:0] clip_sum;
  logic [7:0]  ev_count;
  logic        insufficient;
  logic [15:0] ps_sum;
  logic [7:0]  ps_count;
  logic        ps_flag;
  int          n_chk = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  clipdelay_acc #(.PRESCALE(1), .DLY_W(16), .SUM_W(12), .CNT_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ev_start(ev_start), .ev_done(ev_done),
    .mode_next(mode_next), .fixed_deadline(fixed_deadline),
    .clip_sum(clip_sum), .ev_count(ev_count), .insufficient(insufficient));

  clipdelay_acc #(.PRESCALE(4), .DLY_W(16), .SUM_W(16), .CNT_W(8)) uut_ps (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ev_start(ev_start), .ev_done(ev_done),
    .mode_next(mode_next), .fixed_deadline(fixed_deadline),
    .clip_sum(ps_sum), .ev_count(ps_count), .insufficient(ps_flag));

  task automatic check(input string req, input string what,
                       input int actual, input int expected);
    n_chk++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    ev_start = 1'b1; step(1); ev_start = 1'b0;
  endtask

  task automatic pulse_done();
    ev_done = 1'b1; step(1); ev_done = 1'b0;
  endtask

  task automatic do_clear();
    clr = 1'b1; step(1); clr = 1'b0;
  endtask

  task automatic one_event(input int dly);
    pulse_start(); step(dly - 1); pulse_done();
  endtask

  task automatic t_reset();
    check("R1", "sum after reset", clip_sum, 0);
    check("R1", "count after reset", ev_count, 0);
    check("R1", "flag after reset", insufficient, 0);
  endtask

  task automatic t_fixed();
    do_clear(); mode_next = 1'b0; fixed_deadline = 16'd10;
    one_event(25);
    check("R2", "late event charged its delay", clip_sum, 25);
    check("R2", "count after late event", ev_count, 1);
    step(3); one_event(4);
    check("R2", "early event clipped to deadline", clip_sum, 35);
    step(2); one_event(10);
    check("R2", "event exactly on deadline", clip_sum, 45);
    check("R2", "count after three", ev_count, 3);
  endtask

  task automatic t_fifo();
    do_clear(); mode_next = 1'b0; fixed_deadline = 16'd0;
    pulse_start(); step(2); pulse_start(); step(4); pulse_done();
    check("R3", "done closes oldest", clip_sum, 8);
    step(5); pulse_done();
    check("R3", "second event timed from own start", clip_sum, 19);
    check("R3", "two events counted", ev_count, 2);
  endtask

  task automatic t_overflow();
    do_clear(); mode_next = 1'b0; fixed_deadline = 16'd0;
    pulse_start(); pulse_start(); pulse_start();
    check("R4", "third start raises flag", insufficient, 1);
    step(3); pulse_done(); pulse_done();
    check("R4", "dropped start not timed", clip_sum, 12);
    pulse_done();
    check("R6", "done with none open ignored (count)", ev_count, 2);
    check("R6", "done with none open ignored (sum)", clip_sum, 12);
    check("R4", "flag sticky", insufficient, 1);
    do_clear();
    check("R1", "clear drops flag", insufficient, 0);
    check("R1", "clear zeroes sum", clip_sum, 0);
    pulse_start(); pulse_start(); step(1);
    ev_start = 1'b1; ev_done = 1'b1; step(1); ev_start = 1'b0; ev_done = 1'b0;
    check("R4", "start with done at full accepted", insufficient, 0);
    pulse_done(); pulse_done();
    check("R4", "sum with same-edge retire", clip_sum, 8);
    check("R4", "count with same-edge retire", ev_count, 3);
  endtask

  task automatic t_next();
    do_clear(); mode_next = 1'b1; fixed_deadline = 16'd100;
    pulse_start(); step(4); pulse_done();
    check("R5", "early finish not yet charged", ev_count, 0);
    step(20); pulse_start();
    check("R5", "early finish charged at next start", clip_sum, 26);
    check("R5", "count at next start", ev_count, 1);
    step(4); pulse_start(); step(9); pulse_done();
    check("R5", "late finish charged delay", clip_sum, 41);
    step(2);
    ev_start = 1'b1; ev_done = 1'b1; step(1); ev_start = 1'b0; ev_done = 1'b0;
    check("R5", "done with next start same edge", clip_sum, 54);
    step(1); pulse_done();
    check("R5", "pending holds count", ev_count, 3);
    step(6); pulse_start();
    check("R5", "pending finalised", clip_sum, 63);
    check("R5", "count after finalise", ev_count, 4);
  endtask

  task automatic t_clear_inflight();
    do_clear(); mode_next = 1'b0; fixed_deadline = 16'd0;
    pulse_start(); step(2); do_clear(); step(1); pulse_done();
    check("R1", "clear discards open event", ev_count, 0);
    check("R1", "clear discards open event sum", clip_sum, 0);
  endtask

  task automatic t_saturate();
    do_clear(); mode_next = 1'b0; fixed_deadline = 16'd3000;
    one_event(1);
    check("R7", "sum below max", clip_sum, 3000);
    one_event(1);
    check("R7", "sum saturates", clip_sum, 4095);
    one_event(1);
    check("R7", "sum stays saturated", clip_sum, 4095);
    do_clear(); fixed_deadline = 16'd0;
    for (int i = 0; i < 260; i++) one_event(1);
    check("R7", "count saturates", ev_count, 255);
    check("R7", "sum of 260 unit events", clip_sum, 260);
  endtask

  task automatic t_prescale();
    do_clear(); mode_next = 1'b0; fixed_deadline = 16'd0;
    one_event(40);
    check("R8", "ticks at prescale 4", ps_sum, 10);
    check("R8", "ticks at prescale 1", clip_sum, 40);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; ev_start = 1'b0; ev_done = 1'b0;
    mode_next = 1'b0; fixed_deadline = '0;
    step(3); rst_n = 1'b1; step(4);
    t_reset();
    t_fixed();
    t_fifo();
    t_overflow();
    t_next();
    t_clear_inflight();
    t_saturate();
    t_prescale();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule